// File: doc/BRIEF.md
# Append-Only Record Store Access Engine

This engine makes one page of erase-to-ones flash behave like a small byte-addressed nonvolatile store. A write never modifies a record that is already in the page. It appends a fresh 24-bit record that carries the store address and the data word. A read looks for the newest record of an address by walking the page from its last word toward its first. Word 0 of the page holds page status and is never scanned.

A host sends one request at a time on the request port: a direction, an address, and write data. It gets a one-cycle `req_done` together with a result code and, for reads, the data. The engine drives a word-wide memory port with separate read and program strobes. Read data returns one cycle after the read strobe. Error and warning conditions collect in sticky flag bits that only the host clears. When a write uses the last slot the engine may fill, it raises `pack_req` so that external logic can compact the page. Compaction, erase and power-up recovery are not part of this engine.

Top module: `ee_log_store`

## Requirements
- R1: A record is `{addr[7:0], data[15:0]}`. An address field of 0xFF marks a free slot. A changed write programs the first free slot found by scanning upward from word 1, and it verifies that slot by reading it back.
- R2: A read scans from word PAGE_WORDS-1 down to word 1 and returns the data of the highest-indexed record whose address matches, so the newest copy wins.
- R3: A read of an address that has no record returns 0xFFFF with result 0, and it sets flag bit 0 (not found).
- R4: An address at or above EE_SIZE ends the request with result 5 and rd_data 0xFFFF. It sets flag bit 5 and performs no memory access.
- R5: A write whose data equals the current value of the address (0xFFFF when the address has no record) programs nothing and ends with result 0.
- R6: If the first free slot is at word PAGE_WORDS-1 or beyond, a write programs nothing, ends with result 4 and sets flag bit 4.
- R7: If the read-back differs from the programmed record, the write ends with result 7 and sets flag bit 7.
- R8: A verified write into word PAGE_WORDS-2 raises pack_req at least one cycle before req_done. pack_req then stays high until the next request is accepted. Other successful writes leave it low.
- R9: With page_valid low, a legal request ends with result 6, sets flag bit 6 and performs no memory access.
- R10: Flag bit k holds result code k. Flag bits are set in the req_done cycle and stay set until the host writes a 1 to the matching bit of flag_clr. A set and a clear of the same bit in the same cycle leave the bit set. Bits 1 to 3 are never set by this engine.
- R11: req_start is ignored while a request is in progress. req_done is high for exactly one cycle per accepted request.
- R12: After reset, req_done, pack_req, mem_rd, mem_wr and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Store address |
| req_data | input | 16 | Write data |
| page_valid | input | 1 | A page is marked current |
| flag_clr | input | 8 | Write-one-to-clear mask for the flags |
| req_done | output | 1 | One-cycle completion pulse |
| req_result | output | 3 | 0 on success, otherwise the code of the failing condition |
| rd_data | output | 16 | Read data, valid with req_done |
| flags | output | 8 | Sticky status flags |
| pack_req | output | 1 | Page is full and needs compaction |
| mem_addr | output | AW | Page word index |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Program strobe |
| mem_wdata | output | 24 | Record to program |
| mem_rdata | input | 24 | Read data, one cycle after mem_rd |

## Verification
The host's flag clear and the engine's flag set can land on the same edge: the edge that ends the req_done cycle. The bench provokes this collision by driving flag_clr for the illegal-address bit exactly while req_done is high on an illegal request. It then checks that the bit is still set afterward, and that a clear on a later cycle removes it. A second overlap happens when pack_req rises during the write that fills the page. The bench samples pack_req both in the cycle before req_done and in the req_done cycle itself.

// File: rtl/ee_pkg.sv
package ee_pkg;
    localparam int KEY_W = 8;
    localparam int VAL_W = 16;
    localparam int REC_W = KEY_W + VAL_W;
    localparam logic [KEY_W-1:0] KEY_FREE = '1;
    localparam logic [VAL_W-1:0] VAL_BLANK = '1;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [VAL_W-1:0] val;
    } rec_t;

    typedef enum logic [2:0] {
        RC_OK      = 3'd0,
        RC_EXPIRED = 3'd1,
        RC_EARLY   = 3'd2,
        RC_NOINIT  = 3'd3,
        RC_NOROOM  = 3'd4,
        RC_BADADDR = 3'd5,
        RC_NOPAGE  = 3'd6,
        RC_VERIFY  = 3'd7
    } rcode_t;

    localparam int FLG_MISS = 0;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RREQ, ST_RCHK, ST_FREQ, ST_FCHK,
        ST_PROG, ST_VREQ, ST_VCHK, ST_PACK, ST_DONE
    } st_t;

    function automatic logic [7:0] code_bit(rcode_t c);
        return 8'(1) << c;
    endfunction
endpackage

// File: rtl/ee_addr_gate.sv
module ee_addr_gate #(
    parameter int EE_SIZE = 8
) (
    input  logic [ee_pkg::KEY_W-1:0] addr,
    output logic                     legal
);
    always_comb legal = (32'(addr) < EE_SIZE);
endmodule

// File: rtl/ee_slot_ptr.sv
module ee_slot_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + AW'(1);
        else if (dec)  ptr <= ptr - AW'(1);
    end
endmodule

// File: rtl/ee_log_store.sv
module ee_log_store
    import ee_pkg::*;
#(
    parameter int PAGE_WORDS = 16,
    parameter int EE_SIZE    = 8,
    localparam int AW        = $clog2(PAGE_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_start,
    input  logic             req_write,
    input  logic [KEY_W-1:0] req_addr,
    input  logic [VAL_W-1:0] req_data,
    input  logic             page_valid,
    input  logic [7:0]       flag_clr,
    output logic             req_done,
    output logic [2:0]       req_result,
    output logic [VAL_W-1:0] rd_data,
    output logic [7:0]       flags,
    output logic             pack_req,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [REC_W-1:0] mem_wdata,
    input  logic [REC_W-1:0] mem_rdata
);
    localparam logic [AW-1:0] LAST  = AW'(PAGE_WORDS - 1);
    localparam logic [AW-1:0] FIRST = AW'(1);
    localparam logic [AW-1:0] FINAL = AW'(PAGE_WORDS - 2);

    st_t              state;
    logic             wr_q;
    logic [KEY_W-1:0] key_q;
    logic [VAL_W-1:0] val_q;
    logic [7:0]       set_q;
    rcode_t           res_q;
    logic [VAL_W-1:0] rdat_q;
    logic             legal;
    logic             p_load, p_inc, p_dec;
    logic [AW-1:0]    p_val, ptr;
    rec_t             rec_in, rec_out;

    assign rec_in  = rec_t'(mem_rdata);
    assign rec_out = '{key: key_q, val: val_q};

    ee_addr_gate #(.EE_SIZE(EE_SIZE)) gate_i (.addr(req_addr), .legal(legal));

    ee_slot_ptr #(.AW(AW)) ptr_i (
        .clk(clk), .rst(rst), .load(p_load), .load_val(p_val),
        .inc(p_inc), .dec(p_dec), .ptr(ptr)
    );

    // Pointer control
    always_comb begin
        p_load = 1'b0;
        p_val  = LAST;
        p_inc  = 1'b0;
        p_dec  = 1'b0;
        unique case (state)
            ST_IDLE: p_load = req_start;
            ST_RCHK: begin
                if (rec_in.key == key_q || ptr == FIRST) begin
                    p_load = 1'b1;
                    p_val  = FIRST;
                end else begin
                    p_dec = 1'b1;
                end
            end
            ST_FCHK: p_inc = (rec_in.key != KEY_FREE);
            default: ;
        endcase
    end

    // Memory port
    always_comb begin
        mem_addr  = ptr;
        mem_rd    = (state == ST_RREQ) || (state == ST_VREQ) ||
                    (state == ST_FREQ && ptr < LAST);
        mem_wr    = (state == ST_PROG);
        mem_wdata = rec_out;
    end

    assign req_done = (state == ST_DONE);

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wr_q     <= 1'b0;
            key_q    <= '0;
            val_q    <= '0;
            set_q    <= '0;
            res_q    <= RC_OK;
            rdat_q   <= VAL_BLANK;
            pack_req <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_start) begin
                    wr_q     <= req_write;
                    key_q    <= req_addr;
                    val_q    <= req_data;
                    set_q    <= '0;
                    res_q    <= RC_OK;
                    rdat_q   <= VAL_BLANK;
                    pack_req <= 1'b0;
                    if (!legal) begin
                        set_q <= code_bit(RC_BADADDR);
                        res_q <= RC_BADADDR;
                        state <= ST_DONE;
                    end else if (!page_valid) begin
                        set_q <= code_bit(RC_NOPAGE);
                        res_q <= RC_NOPAGE;
                        state <= ST_DONE;
                    end else begin
                        state <= ST_RREQ;
                    end
                end
                ST_RREQ: state <= ST_RCHK;
                ST_RCHK: begin
                    if (rec_in.key == key_q) begin
                        rdat_q <= rec_in.val;
                        state  <= (wr_q && rec_in.val != val_q) ? ST_FREQ : ST_DONE;
                    end else if (ptr == FIRST) begin
                        rdat_q <= VAL_BLANK;
                        if (!wr_q) set_q[FLG_MISS] <= 1'b1;
                        state  <= (wr_q && val_q != VAL_BLANK) ? ST_FREQ : ST_DONE;
                    end else begin
                        state <= ST_RREQ;
                    end
                end
                ST_FREQ: begin
                    if (ptr >= LAST) begin
                        set_q <= code_bit(RC_NOROOM);
                        res_q <= RC_NOROOM;
                        state <= ST_DONE;
                    end else begin
                        state <= ST_FCHK;
                    end
                end
                ST_FCHK: state <= (rec_in.key == KEY_FREE) ? ST_PROG : ST_FREQ;
                ST_PROG: state <= ST_VREQ;
                ST_VREQ: state <= ST_VCHK;
                ST_VCHK: begin
                    if (mem_rdata != rec_out) begin
                        set_q <= code_bit(RC_VERIFY);
                        res_q <= RC_VERIFY;
                        state <= ST_DONE;
                    end else if (ptr == FINAL) begin
                        pack_req <= 1'b1;
                        state    <= ST_PACK;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_PACK: state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky flags: set in the done cycle wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | (req_done ? set_q : 8'h0);
    end

    assign req_result = res_q;
    assign rd_data    = rdat_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(key_q) && $stable(val_q) && $stable(wr_q));

    // R8
    pack_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pack_req) |=> req_done);

    // R1
    prog_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr != '0) && (mem_addr < LAST) &&
                   (32'(mem_wdata[REC_W-1:VAL_W]) < EE_SIZE));

    // R4
    bad_addr_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_done && req_result == RC_BADADDR) |-> (rd_data == VAL_BLANK));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(flags) & ~flags & ~$past(flag_clr)) == 8'h0));

    // R10
    flag_unused_chk: assert property (@(posedge clk) disable iff (rst)
        flags[3:1] == 3'b000);
endmodule

// File: tb/ee_log_store_tb.sv
`timescale 1ns/1ps
module ee_log_store_tb_top;
    localparam int PW = 16;
    localparam int ES = 8;
    localparam int AW = $clog2(PW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic page_valid = 1'b1;
    logic [7:0] flag_clr = '0;
    logic req_done, pack_req, mem_rd, mem_wr;
    logic [2:0] req_result;
    logic [15:0] rd_data;
    logic [7:0] flags;
    logic [AW-1:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata;

    logic [23:0] mem [PW];
    logic [23:0] fault = '0;
    logic erase_req = 1'b0;
    int n_rd = 0, n_wr = 0;

    int checks = 0, fails = 0;
    logic [2:0] got_res;
    logic [15:0] got_rd;
    logic got_pack, got_pack_prev, got_ok;
    logic [15:0] refv [ES];
    int next_slot;

    always #2.5 clk = ~clk;

    ee_log_store #(.PAGE_WORDS(PW), .EE_SIZE(ES)) dut_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_data(req_data), .page_valid(page_valid),
        .flag_clr(flag_clr), .req_done(req_done), .req_result(req_result),
        .rd_data(rd_data), .flags(flags), .pack_req(pack_req),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural flash page: erase to ones, program clears bits
    always @(posedge clk) begin
        if (erase_req) begin
            for (int i = 1; i < PW; i++) mem[i] <= 24'hFFFFFF;
            mem[0] <= 24'h00FFFE;
        end else if (mem_wr) begin
            mem[mem_addr] <= (mem[mem_addr] & mem_wdata) ^ fault;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_rd) n_rd <= n_rd + 1;
        if (mem_wr) n_wr <= n_wr + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [7:0] a, input logic [15:0] d,
                         input logic [7:0] clr_at_done);
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_data = d;
        @(negedge clk);
        req_start = 1'b0;
        got_ok = 1'b0;
        got_pack_prev = pack_req;
        for (int i = 0; i < 200 && !got_ok; i++) begin
            if (req_done) begin
                got_ok = 1'b1; got_res = req_result; got_rd = rd_data; got_pack = pack_req;
            end else begin
                got_pack_prev = pack_req;
                @(negedge clk);
            end
        end
        if (!got_ok) chk(1'b0, "watchdog R11 no done", 0, 1);
        flag_clr = clr_at_done;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic erase_page();
        @(negedge clk); erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
        next_slot = 1;
        for (int a = 0; a < ES; a++) refv[a] = 16'hFFFF;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 8'hFF;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic write_ok(input logic [7:0] a, input logic [15:0] d);
        do_op(1'b1, a, d, 8'h0);
        chk(got_res == 3'd0, "R1 write result", got_res, 0);
        chk(mem[next_slot] == {a, d}, "R1 record slot", mem[next_slot], {a, d});
        next_slot++;
        refv[a] = d;
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < ES; a++) begin
            do_op(1'b0, 8'(a), 16'h0, 8'h0);
            chk(got_rd == refv[a] && got_res == 3'd0, tag, got_rd, refv[a]);
        end
    endtask

    initial begin
        int w0, r0, dones;
        erase_page();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!req_done && !pack_req && !mem_rd && !mem_wr, "R12 reset outputs", 0, 0);
        chk(flags == 8'h0, "R12 reset flags", flags, 0);

        // R3 empty page reads
        for (int a = 0; a < ES; a++) begin
            do_op(1'b0, 8'(a), 16'h0, 8'h0);
            chk(got_rd == 16'hFFFF && got_res == 3'd0, "R3 unwritten read", got_rd, 16'hFFFF);
        end
        chk(flags == 8'h01, "R3 not-found flag", flags, 8'h01);
        clear_flags();
        chk(flags == 8'h00, "R10 clear", flags, 0);

        // R1 first round of records, slots 1..6
        for (int a = 0; a < 6; a++) write_ok(8'(a), 16'h1000 + 16'(a) * 16'h0111);
        read_all("R2 read after round one");

        // R5 unchanged write
        w0 = n_wr;
        do_op(1'b1, 8'd2, refv[2], 8'h0);
        chk(got_res == 3'd0 && n_wr == w0, "R5 suppressed rewrite", n_wr - w0, 0);
        w0 = n_wr;
        do_op(1'b1, 8'd7, 16'hFFFF, 8'h0);
        chk(got_res == 3'd0 && n_wr == w0, "R5 blank onto unwritten", n_wr - w0, 0);

        // R2 second round, newest copy wins (slots 7..12)
        for (int a = 0; a < 6; a++) write_ok(8'(a), 16'h2000 + 16'(a) * 16'h0222);
        read_all("R2 newest copy");

        // R8 fill the page
        write_ok(8'd6, 16'h6666);
        chk(got_pack == 1'b0, "R8 no pack before last slot", got_pack, 0);
        write_ok(8'd7, 16'h7777);
        chk(got_pack_prev == 1'b1 && got_pack == 1'b1, "R8 pack before done",
            {got_pack_prev, got_pack}, 3);
        @(negedge clk);
        chk(pack_req == 1'b1, "R8 pack held", pack_req, 1);

        // R6 no room
        w0 = n_wr;
        do_op(1'b1, 8'd0, 16'hABCD, 8'h0);
        chk(got_res == 3'd4 && n_wr == w0, "R6 no room", got_res, 4);
        chk(flags[4] == 1'b1, "R6 flag", flags, 8'h10);
        chk(got_pack == 1'b0, "R8 pack cleared on start", got_pack, 0);
        read_all("R6 contents unchanged");

        // R4 illegal address sweep
        w0 = n_wr; r0 = n_rd;
        for (int a = ES; a < 256; a++) begin
            do_op(1'b0, 8'(a), 16'h0, 8'h0);
            chk(got_res == 3'd5 && got_rd == 16'hFFFF, "R4 illegal read", got_rd, 16'hFFFF);
            do_op(1'b1, 8'(a), 16'h1234, 8'h0);
            chk(got_res == 3'd5, "R4 illegal write", got_res, 5);
        end
        chk(n_wr == w0 && n_rd == r0, "R4 no memory access", n_rd - r0 + n_wr - w0, 0);
        chk(flags[5] == 1'b1, "R4 flag", flags, 8'h20);

        // R10 set/clear collision
        clear_flags();
        do_op(1'b0, 8'd200, 16'h0, 8'h20);
        chk(flags[5] == 1'b1, "R10 set wins over clear", flags[5], 1);
        clear_flags();
        chk(flags == 8'h00, "R10 later clear", flags, 0);

        // R9 no current page
        page_valid = 1'b0;
        w0 = n_wr; r0 = n_rd;
        do_op(1'b1, 8'd3, 16'h5555, 8'h0);
        chk(got_res == 3'd6 && n_wr == w0 && n_rd == r0, "R9 no page", got_res, 6);
        chk(flags == 8'h40, "R9 flag", flags, 8'h40);
        page_valid = 1'b1;
        clear_flags();

        // R7 verify failure
        erase_page();
        fault = 24'h000001;
        do_op(1'b1, 8'd3, 16'h3300, 8'h0);
        fault = '0;
        chk(got_res == 3'd7, "R7 verify result", got_res, 7);
        chk(flags == 8'h80, "R7 flag", flags, 8'h80);
        clear_flags();

        // R11 start while busy is ignored
        erase_page();
        w0 = n_wr;
        dones = 0;
        @(negedge clk);
        req_start = 1'b1; req_write = 1'b1; req_addr = 8'd1; req_data = 16'h0A0A;
        @(negedge clk);
        req_addr = 8'd2; req_data = 16'h0B0B;
        repeat (3) begin
            if (req_done) dones++;
            @(negedge clk);
        end
        req_start = 1'b0;
        repeat (80) begin
            if (req_done) dones++;
            @(negedge clk);
        end
        chk(dones == 1, "R11 single done", dones, 1);
        chk(n_wr == w0 + 1 && mem[1] == {8'd1, 16'h0A0A}, "R11 one record", n_wr - w0, 1);
        do_op(1'b0, 8'd2, 16'h0, 8'h0);
        chk(got_rd == 16'hFFFF, "R11 busy start not executed", got_rd, 16'hFFFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule